// File: doc/BRIEF.md
# Codec GPIO Status and Interrupt Unit

This block serves two general-purpose pins inside an audio codec's control register space. Software sees two 16-bit registers: an interrupt enable register and a pin state register. Each pin is set up from outside the block as an input or an output, with a per-pin invert bit and a per-pin latching (sticky) bit. Input pads are asynchronous to the bit clock, so they pass through a synchronizer first. The invert and latch handling is then applied, and the result is what software reads back.

An output pad is driven from the stored state bit by default. When a single global select is raised, the pad is driven from the bits that arrive in the incoming link frame (slot 12) instead. Input pins whose interrupt enable is set are merged into one registered interrupt flag. The framing logic returns that flag to the controller in the outgoing frame. The serial framing itself lies outside the block.

Top module: `gpio_status_irq`

## Requirements
- R1: During and after a synchronous reset, both registers read 0000h, `link_irq` is 0, and with all pins configured as inputs and pads low, `pad_oe` and `pad_out` are 0.
- R2: Only bits [1:0] of either register hold state. Bits [15:2] always read 0, whatever is written to them.
- R3: For a pin configured as output (`cfg_dir_out[n]`=1) with `cfg_link_drive`=0, `pad_oe[n]` is 1. `pad_out[n]` equals the state register bit n, which is written through the register port (`reg_wr_sel`=1) and takes effect on the write edge.
- R4: For a pin configured as output with `cfg_link_drive`=1, `pad_out[n]` follows `link_rx_bits[n]` combinationally.
- R5: For a non-latching input pin, state bit n reads as the pad level XOR the invert bit. The pad passes through a two-flop synchronizer, so a pad change is visible on the read port after the second rising edge and not after the first. Register writes to that bit are ignored.
- R6: For a latching input pin, the state bit goes to 1 on the first edge where the synchronized, inverted input is 1, and it holds after the input drops. Writing 1 to it has no effect. Writing 0 clears it while the input is inactive.
- R7: Setting `cfg_invert[n]` inverts input pin n's reported level immediately on the read port.
- R8: `link_irq` is registered. It is the OR over input pins of (enable bit AND reported state bit), and it updates one edge after the reported state. Output pins never contribute.
- R9: An enable register bit at 0 blocks that pin from `link_irq`. With the whole enable register at 0, `link_irq` is 0 on the next edge.
- R10: For a pin configured as input, `pad_oe[n]` and `pad_out[n]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 enable register, 1 state register |
| reg_wr_data | input | 16 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 enable register, 1 state register |
| reg_rd_data | output | 16 | Read data (combinational) |
| cfg_dir_out | input | 2 | Per-pin direction, 1 = output |
| cfg_invert | input | 2 | Per-pin input invert |
| cfg_sticky | input | 2 | Per-pin input latch enable |
| cfg_link_drive | input | 1 | Output source: 0 state register, 1 link slot bits |
| link_rx_bits | input | 2 | Pin bits received in slot 12 |
| pad_in | input | 2 | Asynchronous pad levels |
| pad_out | output | 2 | Pad drive values |
| pad_oe | output | 2 | Pad output enables |
| link_irq | output | 1 | Registered GPIO interrupt flag for slot 12 |

## Verification
The assertions check on every cycle that the upper register bits read zero and that each output pad matches its selected source, the state bit or the link bit. They also check that input pins never drive, that a zero enable register silences the interrupt on the next edge, and that a latched bit stays set until a clearing write. Only the bench's scenarios can show the two-edge synchronizer latency, that writes are ignored on non-latching inputs, and that a one-cycle pad pulse is caught and held by a latching pin. They also show that the interrupt flag lags the reported state by exactly one edge.

// File: rtl/gpio_stat_pkg.sv
package gpio_stat_pkg;

    localparam int DEF_REG_W    = 16;
    localparam int DEF_NUM_PINS = 2;
    localparam int DEF_SYNC     = 2;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATE  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic dir_out;
        logic invert;
        logic sticky;
    } pin_cfg_t;

    // Next value of one stored state bit.
    function automatic logic state_next(
        input pin_cfg_t cfg,
        input logic     adj,
        input logic     cur,
        input logic     wr_hit,
        input logic     wr_bit
    );
        logic nxt;
        if (cfg.dir_out) begin
            nxt = wr_hit ? wr_bit : cur;
        end else if (!cfg.sticky) begin
            nxt = adj;
        end else if (adj) begin
            nxt = 1'b1;
        end else if (wr_hit && !wr_bit) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

    // Value presented on the read port for one pin.
    function automatic logic state_view(
        input pin_cfg_t cfg,
        input logic     adj,
        input logic     stored
    );
        return (cfg.dir_out || cfg.sticky) ? stored : adj;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     link_drive,
    input  logic     pad_sync,
    input  logic     link_bit,
    input  logic     wr_hit,
    input  logic     wr_bit,
    output logic     view,
    output logic     stored,
    output logic     pad_drive,
    output logic     pad_en
);
    logic adj;
    logic st_q;

    assign adj = pad_sync ^ cfg.invert;

    always_ff @(posedge clk) begin
        if (rst) st_q <= 1'b0;
        else     st_q <= state_next(cfg, adj, st_q, wr_hit, wr_bit);
    end

    assign stored    = st_q;
    assign view      = state_view(cfg, adj, st_q);
    assign pad_en    = cfg.dir_out;
    assign pad_drive = cfg.dir_out ? (link_drive ? link_bit : st_q) : 1'b0;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] view,
    input  logic [WIDTH-1:0] is_output,
    output logic             irq
);
    logic hits;
    logic irq_q;

    assign hits = |(enable & view & ~is_output);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= hits;
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio_status_irq.sv
module gpio_status_irq
    import gpio_stat_pkg::*;
#(
    parameter int REG_W       = DEF_REG_W,
    parameter int NUM_PINS    = DEF_NUM_PINS,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic                reg_wr_sel,
    input  logic [REG_W-1:0]    reg_wr_data,
    input  logic                reg_rd_sel,
    output logic [REG_W-1:0]    reg_rd_data,
    input  logic [NUM_PINS-1:0] cfg_dir_out,
    input  logic [NUM_PINS-1:0] cfg_invert,
    input  logic [NUM_PINS-1:0] cfg_sticky,
    input  logic                cfg_link_drive,
    input  logic [NUM_PINS-1:0] link_rx_bits,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                link_irq
);
    localparam int FILL_W = REG_W - NUM_PINS;

    reg_sel_e wr_target;
    reg_sel_e rd_target;
    logic     wr_enable_hit;
    logic     wr_state_hit;
    logic     unused_wr_hi;

    logic [NUM_PINS-1:0] enable_q;
    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] state_view_w;
    logic [NUM_PINS-1:0] state_q;

    assign wr_target     = reg_sel_e'(reg_wr_sel);
    assign rd_target     = reg_sel_e'(reg_rd_sel);
    assign wr_enable_hit = reg_wr_en && (wr_target == SEL_ENABLE);
    assign wr_state_hit  = reg_wr_en && (wr_target == SEL_STATE);
    assign unused_wr_hi  = ^reg_wr_data[REG_W-1:NUM_PINS];

    always_ff @(posedge clk) begin
        if (rst)                enable_q <= '0;
        else if (wr_enable_hit) enable_q <= reg_wr_data[NUM_PINS-1:0];
    end

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            pin_cfg_t cfg_w;
            assign cfg_w = '{dir_out: cfg_dir_out[p],
                             invert:  cfg_invert[p],
                             sticky:  cfg_sticky[p]};

            gpio_pin_cell cell_i (
                .clk        (clk),
                .rst        (rst),
                .cfg        (cfg_w),
                .link_drive (cfg_link_drive),
                .pad_sync   (pad_sync[p]),
                .link_bit   (link_rx_bits[p]),
                .wr_hit     (wr_state_hit),
                .wr_bit     (reg_wr_data[p]),
                .view       (state_view_w[p]),
                .stored     (state_q[p]),
                .pad_drive  (pad_out[p]),
                .pad_en     (pad_oe[p])
            );
        end
    endgenerate

    gpio_irq_merge #(
        .WIDTH (NUM_PINS)
    ) irq_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable_q),
        .view      (state_view_w),
        .is_output (cfg_dir_out),
        .irq       (link_irq)
    );

    always_comb begin
        if (rd_target == SEL_ENABLE) reg_rd_data = {{FILL_W{1'b0}}, enable_q};
        else                         reg_rd_data = {{FILL_W{1'b0}}, state_view_w};
    end
endmodule

// File: rtl/gpio_status_irq_chk.sv
module gpio_status_irq_chk #(
    parameter int REG_W    = 16,
    parameter int NUM_PINS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr_en,
    input logic                reg_wr_sel,
    input logic [NUM_PINS-1:0] wr_low,
    input logic                reg_rd_sel,
    input logic [REG_W-1:0]    reg_rd_data,
    input logic [NUM_PINS-1:0] cfg_dir_out,
    input logic [NUM_PINS-1:0] cfg_sticky,
    input logic                cfg_link_drive,
    input logic [NUM_PINS-1:0] link_rx_bits,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                link_irq,
    input logic [NUM_PINS-1:0] enable_q,
    input logic [NUM_PINS-1:0] state_q
);
    // R1: the interrupt flag is clear on the edge after reset
    assert_reset_irq_R1: assert property (@(posedge clk) rst |=> !link_irq);

    // R2: upper register bits never carry a 1
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[REG_W-1:NUM_PINS] == '0);

    // R9: a fully cleared enable register silences the flag next edge
    assert_irq_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |=> !link_irq);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
            // R3: register-sourced output pad matches the read-back state bit
            assert_pad_reg_R3: assert property (@(posedge clk) disable iff (rst)
                (reg_rd_sel && cfg_dir_out[p] && !cfg_link_drive)
                    |-> (pad_oe[p] && pad_out[p] == reg_rd_data[p]));

            // R4: link-sourced output pad follows the slot bit
            assert_pad_link_R4: assert property (@(posedge clk) disable iff (rst)
                (cfg_dir_out[p] && cfg_link_drive) |-> (pad_out[p] == link_rx_bits[p]));

            // R10: input pins never drive
            assert_pad_idle_R10: assert property (@(posedge clk) disable iff (rst)
                !cfg_dir_out[p] |-> (!pad_oe[p] && !pad_out[p]));

            // R6: a latched bit survives until a clearing write
            assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (cfg_sticky[p] && !cfg_dir_out[p] && state_q[p]
                    && !(reg_wr_en && reg_wr_sel && !wr_low[p]))
                    |=> (state_q[p] || !cfg_sticky[p] || cfg_dir_out[p]));
        end
    endgenerate
endmodule

bind gpio_status_irq gpio_status_irq_chk #(
    .REG_W    (REG_W),
    .NUM_PINS (NUM_PINS)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_sel     (reg_wr_sel),
    .wr_low         (reg_wr_data[NUM_PINS-1:0]),
    .reg_rd_sel     (reg_rd_sel),
    .reg_rd_data    (reg_rd_data),
    .cfg_dir_out    (cfg_dir_out),
    .cfg_sticky     (cfg_sticky),
    .cfg_link_drive (cfg_link_drive),
    .link_rx_bits   (link_rx_bits),
    .pad_out        (pad_out),
    .pad_oe         (pad_oe),
    .link_irq       (link_irq),
    .enable_q       (enable_q),
    .state_q        (state_q)
);

// File: tb/gpio_status_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_status_irq_tb_top;

    localparam int KIND_RD  = 0;
    localparam int KIND_PAD = 1;
    localparam int KIND_OE  = 2;
    localparam int KIND_IRQ = 3;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic        reg_rd_sel = 1'b0;
    logic [15:0] reg_rd_data;
    logic [1:0]  cfg_dir_out = '0;
    logic [1:0]  cfg_invert = '0;
    logic [1:0]  cfg_sticky = '0;
    logic        cfg_link_drive = 1'b0;
    logic [1:0]  link_rx_bits = '0;
    logic [1:0]  pad_in = '0;
    logic [1:0]  pad_out;
    logic [1:0]  pad_oe;
    logic        link_irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_status_irq dut_i (
        .clk            (clk),
        .rst            (rst),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_sel     (reg_wr_sel),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_sel     (reg_rd_sel),
        .reg_rd_data    (reg_rd_data),
        .cfg_dir_out    (cfg_dir_out),
        .cfg_invert     (cfg_invert),
        .cfg_sticky     (cfg_sticky),
        .cfg_link_drive (cfg_link_drive),
        .link_rx_bits   (link_rx_bits),
        .pad_in         (pad_in),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .link_irq       (link_irq)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                KIND_RD:  act = reg_rd_data;
                KIND_PAD: act = {14'd0, pad_out};
                KIND_OE:  act = {14'd0, pad_oe};
                default:  act = {15'd0, link_irq};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%04h expected=%04h",
                         it.req, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        tick(1);
        reg_wr_en   = 1'b0;
    endtask

    task automatic expect_item(input string req, input int kind, input logic [15:0] exp);
        item_t it;
        it.req  = req;
        it.kind = kind;
        it.exp  = exp;
        sb_q.push_back(it);
        tick(1);
    endtask

    task automatic chk_rd(input string req, input logic sel, input logic [15:0] exp);
        reg_rd_sel = sel;
        expect_item(req, KIND_RD, exp);
    endtask

    initial begin
        tick(3);
        // R1: reset state held while rst is high
        chk_rd("R1 enable during reset", 1'b0, 16'h0000);
        rst = 1'b0;
        chk_rd("R1 enable reset", 1'b0, 16'h0000);
        chk_rd("R1 state reset", 1'b1, 16'h0000);
        expect_item("R1 irq reset", KIND_IRQ, 16'h0000);
        expect_item("R1 oe reset", KIND_OE, 16'h0000);

        // R2: upper bits read zero
        wr(1'b0, 16'hFFFF);
        chk_rd("R2 enable upper bits", 1'b0, 16'h0003);
        // R5: writes to non-latching inputs are ignored
        wr(1'b1, 16'hFFFF);
        chk_rd("R5 write ignored on input", 1'b1, 16'h0000);

        // R3: outputs from the state register
        cfg_dir_out = 2'b11;
        wr(1'b1, 16'hFFFE);
        chk_rd("R2 state upper bits", 1'b1, 16'h0002);
        expect_item("R3 pad from reg", KIND_PAD, 16'h0002);
        expect_item("R3 oe for outputs", KIND_OE, 16'h0003);
        wr(1'b1, 16'h0001);
        expect_item("R3 pad from reg rewrite", KIND_PAD, 16'h0001);

        // R4: outputs from link slot bits
        cfg_link_drive = 1'b1;
        link_rx_bits   = 2'b10;
        expect_item("R4 pad from link", KIND_PAD, 16'h0002);
        link_rx_bits   = 2'b01;
        expect_item("R4 pad from link change", KIND_PAD, 16'h0001);
        // R8: output pins never raise the flag
        expect_item("R8 outputs excluded", KIND_IRQ, 16'h0000);

        // R5: non-latching input with two-edge synchronizer
        cfg_link_drive = 1'b0;
        cfg_dir_out    = 2'b00;
        pad_in         = 2'b01;
        tick(1);
        chk_rd("R5 not visible after one edge", 1'b1, 16'h0000);
        chk_rd("R5 visible after two edges", 1'b1, 16'h0001);
        expect_item("R8 irq one edge later", KIND_IRQ, 16'h0001);
        expect_item("R10 no drive on inputs", KIND_PAD, 16'h0000);
        expect_item("R10 no enable on inputs", KIND_OE, 16'h0000);
        wr(1'b1, 16'h0000);
        chk_rd("R5 clear write ignored", 1'b1, 16'h0001);

        // R7: invert
        cfg_invert = 2'b11;
        chk_rd("R7 inverted read", 1'b1, 16'h0002);

        // R9: enable gating
        wr(1'b0, 16'h0000);
        tick(1);
        expect_item("R9 all blocked", KIND_IRQ, 16'h0000);
        wr(1'b0, 16'h0002);
        tick(1);
        expect_item("R9 pin1 enabled", KIND_IRQ, 16'h0001);

        // R6: latching inputs
        cfg_invert = 2'b00;
        pad_in     = 2'b00;
        cfg_sticky = 2'b11;
        wr(1'b0, 16'h0003);
        tick(3);
        wr(1'b1, 16'h0000);
        chk_rd("R6 cleared", 1'b1, 16'h0000);
        expect_item("R6 irq clear", KIND_IRQ, 16'h0000);
        pad_in = 2'b01;
        tick(1);
        pad_in = 2'b00;
        tick(3);
        chk_rd("R6 pulse latched", 1'b1, 16'h0001);
        expect_item("R8 irq from latched", KIND_IRQ, 16'h0001);
        wr(1'b1, 16'hFFFF);
        chk_rd("R6 write one no effect", 1'b1, 16'h0001);
        wr(1'b1, 16'h0000);
        chk_rd("R6 write zero clears", 1'b1, 16'h0000);
        expect_item("R6 irq after clear", KIND_IRQ, 16'h0000);

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule